// File: doc/BRIEF.md
# Rate-Trimmed Time-of-Day Counter

This block keeps a precision time of day as a 32-bit seconds field and a 30-bit nanosecond field. A slow reference tick (one core-clock cycle in every `TICK_CYCLES`) advances the nanoseconds by a nominal 40 ns. A 32-bit fractional accumulator trims the rate. On every tick it adds a programmable 30-bit magnitude. When it overflows, that tick advances by 41 ns or by 39 ns, and a direction bit chooses which. Between ticks, a phase counter marks the position inside the current 40 ns interval. The live seconds, nanoseconds, phase and tick strobe go out to a trigger unit and to timestamp capture logic.

Software drives the block through a small word-addressed register port with a one-cycle write strobe and a combinational read. A control register holds the run, adjust-enable and step-direction bits. It also carries three self-clearing command bits. The first takes an atomic snapshot of the live time into the shadow registers. The second loads the shadow seconds and nanoseconds into the live counter. The third adds the shadow time to the live time or subtracts it, carrying or borrowing between the nanosecond and seconds fields.

Top module: `tod_counter`

## Requirements
- R1: After reset the live time, the phase, the shadow registers and all control bits are zero. While the run bit (control register address 0, bit 0) is clear, no tick is produced, the phase stays 0 and the time changes only by a load or a step.
- R2: While running, `tick_o` is high in the cycle where the phase equals `TICK_CYCLES-1`. The phase counts 0 up to `TICK_CYCLES-1` once per clock. At that clock edge the nanoseconds advance by the tick's increment, which is 40 when no correction applies.
- R3: When an advance brings the nanoseconds to 1,000,000,000 or beyond, that value is subtracted and the seconds increase by one. Seconds wrap modulo 2^32.
- R4: Bit 1 of the control register is the adjust-enable bit. While it is set, each tick adds the rate magnitude (address 4, bits 29:0) to a 32-bit fraction. A carry out of the fraction makes that tick's increment 41 when the rate direction bit (address 4, bit 31) is 1, and 39 when it is 0. With no carry the increment is 40. Address 4 reads back as written.
- R5: While adjust-enable is clear, every tick advances by exactly 40 and the fraction holds its value.
- R6: Writing control bit 3 (snapshot) copies the live seconds, nanoseconds and phase into the shadow registers at that edge. The shadow registers read back at address 2 (seconds), address 1 (nanoseconds, bits 29:0) and address 3 (phase). Each phase step is `40/TICK_CYCLES` ns, which is 8 ns with the defaults.
- R7: Writing control bit 4 (load) puts the shadow seconds and nanoseconds into the live counter, and clears both the phase and the fraction. Software keeps the shadow nanoseconds below 1,000,000,000.
- R8: Writing control bit 5 (step) together with bit 2 set adds the shadow time to the live time. A nanosecond sum of 1,000,000,000 or more wraps and carries one into the seconds.
- R9: Writing control bit 5 with bit 2 clear subtracts the shadow time from the live time. A nanosecond underflow adds 1,000,000,000 and borrows one from the seconds, and the seconds wrap modulo 2^32.
- R10: A load or step in a tick cycle replaces that tick's advance, and the fraction does not move. When load and step are written together, load wins.
- R11: The three command bits (3, 4 and 5) self-clear and always read back as 0. Bits 0 to 2 of address 0 read back as last written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write address |
| wr_data | input | DATA_W | Register write data |
| rd_addr | input | ADDR_W | Register read address |
| rd_data | output | DATA_W | Combinational read data |
| time_sec | output | SEC_W | Live seconds |
| time_ns | output | NS_W | Live nanoseconds |
| time_phase | output | PH_W | Position inside the current tick interval |
| tick_o | output | 1 | High in the cycle whose clock edge advances the time |

## Verification
A register write is acted on at the rising edge that samples it. Its effect on the live time, the shadow registers and the read-back is therefore visible for the whole of the following cycle. `tick_o` and `rd_data` are combinational from the state held in the current cycle, and the time they announce appears one edge later. The bench drives its inputs and compares every output at the falling edge. It advances its behavioural model by exactly one edge per cycle, so each result is checked in the cycle it falls due. Loads and steps are issued in cycles the model marks as tick cycles, to exercise the priority rule.

// File: rtl/tod_pkg.sv
package tod_pkg;

   // register addresses
   localparam int unsigned A_CTRL   = 0;
   localparam int unsigned A_SH_NS  = 1;
   localparam int unsigned A_SH_SEC = 2;
   localparam int unsigned A_PHASE  = 3;
   localparam int unsigned A_RATE   = 4;

   // control register bit positions
   localparam int unsigned B_RUN  = 0;
   localparam int unsigned B_ADJ  = 1;
   localparam int unsigned B_DIR  = 2;
   localparam int unsigned B_SNAP = 3;
   localparam int unsigned B_LOAD = 4;
   localparam int unsigned B_STEP = 5;

   typedef struct packed {
      logic run;
      logic adj;
      logic dir;
   } tod_ctrl_t;

   typedef struct packed {
      logic snap;
      logic load;
      logic step;
      logic step_add;
   } tod_cmd_t;

endpackage

// File: rtl/tod_regs.sv
module tod_regs
   import tod_pkg::*;
#(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 3,
   parameter int unsigned SEC_W  = 32,
   parameter int unsigned NS_W   = 30,
   parameter int unsigned MAG_W  = 30,
   parameter int unsigned PH_W   = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic [ADDR_W-1:0] rd_addr_i,
   output logic [DATA_W-1:0] rd_data_o,
   input  logic [SEC_W-1:0]  live_sec_i,
   input  logic [NS_W-1:0]   live_ns_i,
   input  logic [PH_W-1:0]   live_ph_i,
   output tod_ctrl_t         ctrl_o,
   output tod_cmd_t          cmd_o,
   output logic [SEC_W-1:0]  sh_sec_o,
   output logic [NS_W-1:0]   sh_ns_o,
   output logic [MAG_W-1:0]  rate_mag_o,
   output logic              rate_dir_o
);

   localparam logic [ADDR_W-1:0] AD_CTRL   = ADDR_W'(A_CTRL);
   localparam logic [ADDR_W-1:0] AD_SH_NS  = ADDR_W'(A_SH_NS);
   localparam logic [ADDR_W-1:0] AD_SH_SEC = ADDR_W'(A_SH_SEC);
   localparam logic [ADDR_W-1:0] AD_PHASE  = ADDR_W'(A_PHASE);
   localparam logic [ADDR_W-1:0] AD_RATE   = ADDR_W'(A_RATE);

   logic [PH_W-1:0] sh_ph_q;
   logic            ctrl_wr;

   assign ctrl_wr = wr_en_i && (wr_addr_i == AD_CTRL);

   // command strobes exist only in the cycle of the control write
   always_comb begin
      cmd_o = '0;
      if (ctrl_wr) begin
         cmd_o.snap     = wr_data_i[B_SNAP];
         cmd_o.load     = wr_data_i[B_LOAD];
         cmd_o.step     = wr_data_i[B_STEP];
         cmd_o.step_add = wr_data_i[B_DIR];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctrl_o     <= '0;
         sh_sec_o   <= '0;
         sh_ns_o    <= '0;
         sh_ph_q    <= '0;
         rate_mag_o <= '0;
         rate_dir_o <= 1'b0;
      end else begin
         if (cmd_o.snap) begin
            sh_sec_o <= live_sec_i;
            sh_ns_o  <= live_ns_i;
            sh_ph_q  <= live_ph_i;
         end
         if (wr_en_i) begin
            case (wr_addr_i)
               AD_CTRL: begin
                  ctrl_o.run <= wr_data_i[B_RUN];
                  ctrl_o.adj <= wr_data_i[B_ADJ];
                  ctrl_o.dir <= wr_data_i[B_DIR];
               end
               AD_SH_NS:  sh_ns_o  <= wr_data_i[NS_W-1:0];
               AD_SH_SEC: sh_sec_o <= wr_data_i[SEC_W-1:0];
               AD_RATE: begin
                  rate_mag_o <= wr_data_i[MAG_W-1:0];
                  rate_dir_o <= wr_data_i[DATA_W-1];
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      rd_data_o = '0;
      case (rd_addr_i)
         AD_CTRL: begin
            rd_data_o[B_RUN] = ctrl_o.run;
            rd_data_o[B_ADJ] = ctrl_o.adj;
            rd_data_o[B_DIR] = ctrl_o.dir;
         end
         AD_SH_NS:  rd_data_o = DATA_W'(sh_ns_o);
         AD_SH_SEC: rd_data_o = DATA_W'(sh_sec_o);
         AD_PHASE:  rd_data_o = DATA_W'(sh_ph_q);
         AD_RATE: begin
            rd_data_o[MAG_W-1:0] = rate_mag_o;
            rd_data_o[DATA_W-1]  = rate_dir_o;
         end
         default: rd_data_o = '0;
      endcase
   end

   AST_SNAP_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_o.snap |=> (sh_sec_o == $past(live_sec_i)) && (sh_ns_o == $past(live_ns_i)) && (sh_ph_q == $past(live_ph_i))); // R6

endmodule

// File: rtl/tod_ticker.sv
module tod_ticker #(
   parameter int unsigned TICK_CYCLES = 5,
   localparam int unsigned PH_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            run_i,
   input  logic            restart_i,
   output logic [PH_W-1:0] phase_o,
   output logic            tick_o
);

   localparam logic [PH_W-1:0] LAST = PH_W'(TICK_CYCLES - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_o <= '0;
      end else if (restart_i || !run_i) begin
         phase_o <= '0;
      end else if (phase_o == LAST) begin
         phase_o <= '0;
      end else begin
         phase_o <= phase_o + 1'b1;
      end
   end

   assign tick_o = run_i && (phase_o == LAST);

   AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      phase_o <= LAST); // R2

   AST_TICK_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      tick_o |=> (phase_o == '0)); // R2

endmodule

// File: rtl/tod_accum.sv
module tod_accum #(
   parameter int unsigned FRAC_W  = 32,
   parameter int unsigned MAG_W   = 30,
   parameter int unsigned NOM_INC = 40,
   parameter int unsigned INC_W   = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             adv_i,
   input  logic             adj_i,
   input  logic             dir_i,
   input  logic [MAG_W-1:0] mag_i,
   output logic [INC_W-1:0] inc_o
);

   localparam logic [INC_W-1:0] INC_NOM  = INC_W'(NOM_INC);
   localparam logic [INC_W-1:0] INC_FAST = INC_W'(NOM_INC + 1);
   localparam logic [INC_W-1:0] INC_SLOW = INC_W'(NOM_INC - 1);

   logic [FRAC_W-1:0] frac_q;
   logic [FRAC_W-1:0] addend;
   logic [FRAC_W:0]   sum;
   logic              carry;

   generate
      if (MAG_W == FRAC_W) begin : g_full
         assign addend = mag_i;
      end else begin : g_ext
         assign addend = {{(FRAC_W-MAG_W){1'b0}}, mag_i};
      end
   endgenerate

   assign sum   = {1'b0, frac_q} + {1'b0, addend};
   assign carry = sum[FRAC_W];

   always_comb begin
      if (adj_i && carry) begin
         inc_o = dir_i ? INC_FAST : INC_SLOW;
      end else begin
         inc_o = INC_NOM;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frac_q <= '0;
      end else if (clr_i) begin
         frac_q <= '0;
      end else if (adv_i && adj_i) begin
         frac_q <= sum[FRAC_W-1:0];
      end
   end

   AST_INC_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_o >= INC_SLOW) && (inc_o <= INC_FAST)); // R4

   AST_FRAC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i && !(adv_i && adj_i)) |=> $stable(frac_q)); // R5

   AST_FRAC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (frac_q == '0)); // R7

endmodule

// File: rtl/tod_time.sv
module tod_time #(
   parameter int unsigned SEC_W      = 32,
   parameter int unsigned NS_W       = 30,
   parameter int unsigned NS_PER_SEC = 1000000000,
   parameter int unsigned INC_W      = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv_i,
   input  logic [INC_W-1:0] inc_i,
   input  logic             load_i,
   input  logic             step_i,
   input  logic             step_add_i,
   input  logic [SEC_W-1:0] sh_sec_i,
   input  logic [NS_W-1:0]  sh_ns_i,
   output logic [SEC_W-1:0] sec_o,
   output logic [NS_W-1:0]  ns_o
);

   localparam int unsigned W = NS_W + 1;
   localparam logic [W-1:0] NSPS = W'(NS_PER_SEC);

   logic [W-1:0] tick_sum, add_sum, sub_diff;
   logic         tick_c, add_c, sub_b;
   logic [NS_W-1:0]  tick_ns, add_ns, sub_ns;
   logic [SEC_W-1:0] tick_sec, add_sec, sub_sec;

   // tick advance
   assign tick_sum = {1'b0, ns_o} + W'(inc_i);
   assign tick_c   = tick_sum >= NSPS;
   assign tick_ns  = tick_c ? NS_W'(tick_sum - NSPS) : NS_W'(tick_sum);
   assign tick_sec = sec_o + SEC_W'(tick_c);

   // step forward
   assign add_sum = {1'b0, ns_o} + {1'b0, sh_ns_i};
   assign add_c   = add_sum >= NSPS;
   assign add_ns  = add_c ? NS_W'(add_sum - NSPS) : NS_W'(add_sum);
   assign add_sec = sec_o + sh_sec_i + SEC_W'(add_c);

   // step backward
   assign sub_diff = {1'b0, ns_o} - {1'b0, sh_ns_i};
   assign sub_b    = ns_o < sh_ns_i;
   assign sub_ns   = sub_b ? NS_W'(sub_diff + NSPS) : NS_W'(sub_diff);
   assign sub_sec  = sec_o - sh_sec_i - SEC_W'(sub_b);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sec_o <= '0;
         ns_o  <= '0;
      end else if (load_i) begin
         sec_o <= sh_sec_i;
         ns_o  <= sh_ns_i;
      end else if (step_i) begin
         sec_o <= step_add_i ? add_sec : sub_sec;
         ns_o  <= step_add_i ? add_ns  : sub_ns;
      end else if (adv_i) begin
         sec_o <= tick_sec;
         ns_o  <= tick_ns;
      end
   end

   AST_NS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      ((ns_o < NS_W'(NS_PER_SEC)) && !load_i) |=> (ns_o < NS_W'(NS_PER_SEC))); // R3

   AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!adv_i && !load_i && !step_i) |=> ($stable(sec_o) && $stable(ns_o))); // R1

   AST_LOAD_COPY: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> ((sec_o == $past(sh_sec_i)) && (ns_o == $past(sh_ns_i)))); // R7

endmodule

// File: rtl/tod_counter.sv
module tod_counter
   import tod_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 3,
   parameter int unsigned SEC_W       = 32,
   parameter int unsigned NS_W        = 30,
   parameter int unsigned FRAC_W      = 32,
   parameter int unsigned MAG_W       = 30,
   parameter int unsigned NOM_INC     = 40,
   parameter int unsigned NS_PER_SEC  = 1000000000,
   parameter int unsigned TICK_CYCLES = 5,
   localparam int unsigned PH_W  = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1,
   localparam int unsigned INC_W = $clog2(NOM_INC + 2)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   output logic [SEC_W-1:0]  time_sec,
   output logic [NS_W-1:0]   time_ns,
   output logic [PH_W-1:0]   time_phase,
   output logic              tick_o
);

   // elaboration-time parameter checks
   generate
      if ((64'd1 << NS_W) <= 64'(NS_PER_SEC)) begin : g_chk_ns
         $error("NS_W too narrow for NS_PER_SEC");
      end
      if (MAG_W > FRAC_W) begin : g_chk_mag
         $error("MAG_W must not exceed FRAC_W");
      end
      if (MAG_W >= DATA_W || SEC_W > DATA_W || NS_W > DATA_W) begin : g_chk_data
         $error("fields do not fit DATA_W");
      end
      if (TICK_CYCLES < 2 || NOM_INC < 2) begin : g_chk_tick
         $error("TICK_CYCLES and NOM_INC must be at least 2");
      end
      if ((1 << ADDR_W) <= A_RATE) begin : g_chk_addr
         $error("ADDR_W too narrow for register map");
      end
   endgenerate

   tod_ctrl_t        ctrl;
   tod_cmd_t         cmd;
   logic [SEC_W-1:0] sh_sec;
   logic [NS_W-1:0]  sh_ns;
   logic [MAG_W-1:0] rate_mag;
   logic             rate_dir;
   logic [INC_W-1:0] inc;
   logic             tick;
   logic             adv;

   assign adv    = tick && !cmd.load && !cmd.step;
   assign tick_o = tick;

   tod_regs #(
      .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SEC_W(SEC_W),
      .NS_W(NS_W), .MAG_W(MAG_W), .PH_W(PH_W)
   ) regs_i (
      .clk(clk), .rst_n(rst_n),
      .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
      .rd_addr_i(rd_addr), .rd_data_o(rd_data),
      .live_sec_i(time_sec), .live_ns_i(time_ns), .live_ph_i(time_phase),
      .ctrl_o(ctrl), .cmd_o(cmd),
      .sh_sec_o(sh_sec), .sh_ns_o(sh_ns),
      .rate_mag_o(rate_mag), .rate_dir_o(rate_dir)
   );

   tod_ticker #(.TICK_CYCLES(TICK_CYCLES)) ticker_i (
      .clk(clk), .rst_n(rst_n),
      .run_i(ctrl.run), .restart_i(cmd.load),
      .phase_o(time_phase), .tick_o(tick)
   );

   tod_accum #(
      .FRAC_W(FRAC_W), .MAG_W(MAG_W), .NOM_INC(NOM_INC), .INC_W(INC_W)
   ) accum_i (
      .clk(clk), .rst_n(rst_n),
      .clr_i(cmd.load), .adv_i(adv), .adj_i(ctrl.adj),
      .dir_i(rate_dir), .mag_i(rate_mag), .inc_o(inc)
   );

   tod_time #(
      .SEC_W(SEC_W), .NS_W(NS_W), .NS_PER_SEC(NS_PER_SEC), .INC_W(INC_W)
   ) time_i (
      .clk(clk), .rst_n(rst_n),
      .adv_i(adv), .inc_i(inc),
      .load_i(cmd.load), .step_i(cmd.step), .step_add_i(cmd.step_add),
      .sh_sec_i(sh_sec), .sh_ns_i(sh_ns),
      .sec_o(time_sec), .ns_o(time_ns)
   );

endmodule

// File: tb/tod_counter_tb_top.sv
`timescale 1ns/1ps
module tod_counter_tb_top;

   localparam int TC = 5;
   localparam longint NSPS = 1000000000;
   localparam longint M32 = 64'hFFFF_FFFF;
   localparam longint M30 = 64'h3FFF_FFFF;
   localparam bit [31:0] C_RUN = 32'h1, C_ADJ = 32'h2, C_DIR = 32'h4,
                         C_SNAP = 32'h8, C_LOAD = 32'h10, C_STEP = 32'h20;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [31:0] time_sec;
   logic [29:0] time_ns;
   logic [2:0]  time_phase;
   logic        tick_o;

   always #2.5 clk = ~clk;

   tod_counter dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .time_sec(time_sec), .time_ns(time_ns), .time_phase(time_phase),
      .tick_o(tick_o)
   );

   int    tests = 0;
   int    fails = 0;
   bit    done = 0;
   string cur_req = "R1";

   // behavioural reference state
   longint m_sec, m_ns, m_ph, m_frac, m_mag, sh_sec, sh_ns, sh_ph;
   bit     m_run, m_adj, m_dir, m_rdir;
   int     m_rd;

   bit     p_valid = 0;
   string  p_req;
   longint p_sec, p_ns;

   task automatic chk(string req, string what, longint act, longint exp);
      tests++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s %s act=%0d exp=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic longint mreg(int a);
      case (a)
         0: mreg = longint'({m_dir, m_adj, m_run});
         1: mreg = sh_ns;
         2: mreg = sh_sec;
         3: mreg = sh_ph;
         4: mreg = (longint'(m_rdir) << 31) | m_mag;
         default: mreg = 0;
      endcase
   endfunction

   task automatic model_next(bit we, int a, bit [31:0] d);
      bit tk, ld, st, sn, sd;
      longint n_sec, n_ns, n_ph, n_frac, s, inc;
      tk = m_run && (m_ph == TC-1);
      ld = 0; st = 0; sn = 0; sd = 0;
      if (we && a == 0) begin ld = d[4]; st = d[5]; sn = d[3]; sd = d[2]; end
      n_sec = m_sec; n_ns = m_ns; n_frac = m_frac;
      if (ld) begin
         n_sec = sh_sec; n_ns = sh_ns; n_ph = 0; n_frac = 0;
      end else begin
         n_ph = !m_run ? 0 : ((m_ph == TC-1) ? 0 : m_ph + 1);
         if (st) begin
            if (sd) begin
               n_ns = m_ns + sh_ns; n_sec = m_sec + sh_sec;
               if (n_ns >= NSPS) begin n_ns -= NSPS; n_sec += 1; end
            end else begin
               n_ns = m_ns - sh_ns; n_sec = m_sec - sh_sec;
               if (n_ns < 0) begin n_ns += NSPS; n_sec -= 1; end
            end
            n_sec &= M32;
         end else if (tk) begin
            inc = 40;
            if (m_adj) begin
               s = m_frac + m_mag;
               if (s > M32) inc = m_rdir ? 41 : 39;
               n_frac = s & M32;
            end
            n_ns = m_ns + inc;
            if (n_ns >= NSPS) begin n_ns -= NSPS; n_sec = (m_sec + 1) & M32; end
         end
      end
      if (sn) begin sh_sec = m_sec; sh_ns = m_ns; sh_ph = m_ph; end
      if (we) begin
         case (a)
            0: begin m_run = d[0]; m_adj = d[1]; m_dir = d[2]; end
            1: sh_ns = longint'(d) & M30;
            2: sh_sec = longint'(d) & M32;
            4: begin m_mag = longint'(d) & M30; m_rdir = d[31]; end
            default: ;
         endcase
      end
      m_sec = n_sec; m_ns = n_ns; m_ph = n_ph; m_frac = n_frac;
   endtask

   // one clock: compare current outputs, then drive and advance the model
   task automatic cyc(bit we, int a, bit [31:0] d);
      string rtag;
      @(negedge clk);
      chk(cur_req, "time_sec", longint'(time_sec), m_sec);
      chk(cur_req, "time_ns", longint'(time_ns), m_ns);
      chk(cur_req, "time_phase", longint'(time_phase), m_ph);
      chk("R2", "tick_o", longint'(tick_o), longint'(m_run && (m_ph == TC-1)));
      rtag = (m_rd == 0) ? "R11" : ((m_rd == 4) ? "R4" : "R6");
      chk(rtag, $sformatf("rd_data[%0d]", m_rd), longint'(rd_data), mreg(m_rd));
      if (p_valid) begin
         chk(p_req, "fixed time_sec", longint'(time_sec), p_sec);
         chk(p_req, "fixed time_ns", longint'(time_ns), p_ns);
         p_valid = 0;
      end
      m_rd = (m_rd + 1) % 5;
      wr_en = we; wr_addr = a[2:0]; wr_data = d; rd_addr = m_rd[2:0];
      model_next(we, a, d);
   endtask

   task automatic idle(int n);
      for (int i = 0; i < n; i++) cyc(0, 0, 32'h0);
   endtask

   task automatic wr(int a, bit [31:0] d);
      cyc(1, a, d);
   endtask

   task automatic expect_next(string req, longint s, longint n);
      p_valid = 1; p_req = req; p_sec = s; p_ns = n;
   endtask

   task automatic wait_tick();
      for (int g = 0; g < 20 && !(m_run && (m_ph == TC-1)); g++) idle(1);
   endtask

   task automatic summary();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
   endtask

   initial begin
      m_sec = 0; m_ns = 0; m_ph = 0; m_frac = 0; m_mag = 0;
      sh_sec = 0; sh_ns = 0; sh_ph = 0;
      m_run = 0; m_adj = 0; m_dir = 0; m_rdir = 0; m_rd = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state, frozen while stopped
      cur_req = "R1";
      expect_next("R1", 0, 0);
      idle(12);

      // R2: nominal run
      cur_req = "R2";
      wr(0, C_RUN);
      idle(60);

      // R7: load while stopped, R3 rollover
      cur_req = "R7";
      wr(1, 32'd999_999_950);
      wr(2, 32'd5);
      wr(0, C_LOAD);
      expect_next("R7", 5, 999_999_950);
      idle(3);
      cur_req = "R3";
      wr(0, C_RUN);
      idle(20);
      // seconds wrap
      wr(1, 32'd999_999_990);
      wr(2, 32'hFFFF_FFFF);
      wr(0, C_RUN | C_LOAD);
      expect_next("R7", 32'hFFFF_FFFF, 999_999_990);
      idle(12);

      // R4: rate correction both directions
      cur_req = "R4";
      wr(4, 32'h8000_0000 | 32'h3FFF_FFFF);
      wr(0, C_RUN | C_ADJ);
      idle(150);
      wr(4, 32'h3FFF_FFFF);
      idle(150);
      wr(4, 32'h8000_0000 | 32'h2000_0000);
      idle(80);

      // R5: correction disabled
      cur_req = "R5";
      wr(0, C_RUN);
      idle(80);

      // R6: snapshot while running and while stopped
      cur_req = "R6";
      wr(0, C_RUN | C_SNAP);
      idle(7);
      wr(0, 32'h0);
      idle(3);
      wr(0, C_SNAP);
      idle(7);

      // R8: step forward with carry
      cur_req = "R8";
      wr(0, C_RUN);
      wr(1, 32'd999_000_000);
      wr(2, 32'd3);
      wr(0, C_RUN | C_DIR | C_STEP);
      idle(12);

      // R9: step backward with borrow, then seconds underflow
      cur_req = "R9";
      wr(1, 32'd999_999_999);
      wr(2, 32'd1);
      wr(0, C_RUN | C_STEP);
      idle(12);
      wr(1, 32'd100);
      wr(2, 32'd0);
      wr(0, C_LOAD);
      idle(2);
      wr(1, 32'd200);
      wr(2, 32'd2);
      wr(0, C_STEP);
      expect_next("R9", 32'hFFFF_FFFD, 999_999_900);
      idle(4);

      // R10: commands in tick cycles
      cur_req = "R10";
      wr(0, C_RUN | C_ADJ);
      wr(4, 32'h8000_0000 | 32'h3FFF_FFFF);
      wr(1, 32'd1234);
      wr(2, 32'd9);
      wait_tick();
      chk("R10", "tick aligned", longint'(m_run && (m_ph == TC-1)), 1);
      wr(0, C_RUN | C_ADJ | C_LOAD);
      expect_next("R10", 9, 1234);
      idle(7);
      wait_tick();
      wr(0, C_RUN | C_ADJ | C_DIR | C_STEP);
      idle(7);
      wait_tick();
      wr(0, C_RUN | C_LOAD | C_STEP | C_DIR);
      expect_next("R10", 9, 1234);
      idle(7);

      // R11: strobes read back as zero, plain bits as written
      cur_req = "R11";
      wr(0, C_RUN | C_DIR | C_SNAP);
      idle(10);

      idle(1);
      done = 1;
      summary();
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         tests++;
         fails++;
         $display("FAIL %s watchdog act=hung exp=finished", cur_req);
         summary();
         $finish;
      end
   end

endmodule